// File: doc/BRIEF.md
# Pulse-Swallow Divider Counter

This block is the digital counting stage that sits behind a dual-modulus prescaler dividing by M or M+1 (M = 8 by default). It runs on the prescaler's output clock and holds two down-counters: a program counter and a swallow counter. At the start of every output cycle it loads both counters. The modulus-control output asks the prescaler for M+1 while the swallow counter is non-zero and for M after that. When the program counter reaches its last count, the block marks the output cycle and reloads. Over one output cycle the VCO is therefore divided by N = P*M + S.

The ratio can change from one output cycle to the next. A signed 3-bit correction from a sigma-delta modulator is added to the programmed integer ratio. The sum is split into new program and swallow values, and these are taken only at the reload edge, so an update cannot corrupt an output cycle that is already running. A value whose swallow count would exceed its program count cannot be produced by this structure. Such a value, and any ratio outside what the counters can hold, is forced to the nearest value the counters can produce, and a flag reports this for the whole affected cycle.

Top module: `pss_divider_counter`

## Requirements
- R1: While `rst_n` is low, `mod_ctl`, `div_out` and `clamp_flag` are 0. The first rising `pclk` edge after release loads the program that is then present.
- R2: An output cycle lasts exactly P prescaler periods and spans N = P*8 + S VCO cycles, where a period with `mod_ctl` high counts 9 and one with it low counts 8.
- R3: The requested ratio is `prog_p`*8 + `prog_s` + `ratio_adj`, with `ratio_adj` in two's complement (-4..3). P is that ratio divided by 8 and S is the remainder.
- R4: Within an output cycle, `mod_ctl` is high for the first S prescaler periods and low for all later ones.
- R5: `div_out` is high during the last prescaler period of each output cycle and low during the others. With P = 1 it therefore stays high.
- R6: The program inputs are sampled only on the reload edge. A change in the middle of a cycle does not alter that cycle and takes effect in the next one.
- R7: If S would exceed P, S is set to P and `clamp_flag` is high for that output cycle.
- R8: A requested ratio below 8 (negative counts as 0) gives P = 1 and S = 0. A ratio whose P exceeds 63 gives P = 63 and S = 7. `clamp_flag` is high for that cycle in both cases and low in any cycle that needed no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_p | input | 6 | Integer ratio, quotient part |
| prog_s | input | 3 | Integer ratio, remainder part |
| ratio_adj | input | 3 | Signed per-cycle correction from the modulator |
| mod_ctl | output | 1 | 1 requests divide by M+1, 0 requests divide by M |
| div_out | output | 1 | Divided clock, high in the last period of a cycle |
| clamp_flag | output | 1 | The current cycle's ratio was corrected |

## Verification
A wrong counter state shows at the ports within the same output cycle. A wrong load value changes how many periods pass until `div_out` rises and how many periods `mod_ctl` is high, so the VCO-cycle total measured for that cycle is wrong. A swallow counter that is not in step with the program counter breaks the single high-then-low shape of `mod_ctl`. A late or early sample of the program shows up as a wrong total for exactly one cycle, either the cycle in which the inputs changed or the cycle after it.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Requested ratio in VCO cycles; a negative request is treated as zero.
  function automatic int compose_ratio(input int p, input int s, input int adj, input int m);
    int n;
    n = p * m + s + adj;
    return (n < 0) ? 0 : n;
  endfunction

  function automatic int ratio_quot(input int n, input int m);
    return n / m;
  endfunction

  function automatic int ratio_rem(input int n, input int m);
    return n % m;
  endfunction

endpackage

// File: rtl/pss_ratio_resolve.sv
module pss_ratio_resolve #(
  parameter int M    = 8,
  parameter int P_W  = 6,
  parameter int S_W  = 3,
  parameter int DN_W = 3
) (
  input  logic [P_W-1:0]  p_in,
  input  logic [S_W-1:0]  s_in,
  input  logic [DN_W-1:0] adj_in,
  output logic [P_W-1:0]  p_out,
  output logic [S_W-1:0]  s_out,
  output logic            fix
);
  localparam int P_MAX = (2 ** P_W) - 1;

  int n, q, r;

  always_comb begin
    n   = pss_pkg::compose_ratio(int'(p_in), int'(s_in), int'($signed(adj_in)), M);
    q   = pss_pkg::ratio_quot(n, M);
    r   = pss_pkg::ratio_rem(n, M);
    fix = 1'b0;
    if (q > P_MAX) begin
      q   = P_MAX;
      r   = M - 1;
      fix = 1'b1;
    end
    if (q == 0) begin
      q   = 1;
      r   = 0;
      fix = 1'b1;
    end
    if (r > q) begin
      r   = q;
      fix = 1'b1;
    end
    p_out = P_W'(q);
    s_out = S_W'(r);
  end

  // The resolved pair is always one the counters can realise.
  always_comb begin
    if (!$isunknown({p_in, s_in, adj_in})) begin
      assert_swallow_within_program_R7: assert (int'(s_out) <= int'(p_out));
      assert_program_nonzero_R8: assert (p_out != '0);
    end
  end
endmodule

// File: rtl/pss_count.sv
module pss_count #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/pss_divider_counter.sv
module pss_divider_counter #(
  parameter  int M    = 8,
  parameter  int P_W  = 6,
  parameter  int DN_W = 3,
  localparam int S_W  = $clog2(M)
) (
  input  logic            pclk,
  input  logic            rst_n,
  input  logic [P_W-1:0]  prog_p,
  input  logic [S_W-1:0]  prog_s,
  input  logic [DN_W-1:0] ratio_adj,
  output logic            mod_ctl,
  output logic            div_out,
  output logic            clamp_flag
);
  logic [P_W-1:0] p_res, pcnt;
  logic [S_W-1:0] s_res, scnt;
  logic           fix_res;
  logic           reload;

  pss_ratio_resolve #(.M(M), .P_W(P_W), .S_W(S_W), .DN_W(DN_W)) u_resolve (
    .p_in(prog_p), .s_in(prog_s), .adj_in(ratio_adj),
    .p_out(p_res), .s_out(s_res), .fix(fix_res)
  );

  // Reload on the last period of a cycle, or on the first edge after reset.
  assign reload = (pcnt <= P_W'(1));

  pss_count #(.W(P_W)) u_prog (
    .clk(pclk), .rst_n(rst_n), .load(reload), .ld_val(p_res), .cnt(pcnt)
  );

  pss_count #(.W(S_W)) u_swallow (
    .clk(pclk), .rst_n(rst_n), .load(reload), .ld_val(s_res), .cnt(scnt)
  );

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n)      clamp_flag <= 1'b0;
    else if (reload) clamp_flag <= fix_res;
  end

  assign mod_ctl = (scnt != '0);
  assign div_out = (pcnt == P_W'(1));

  assert_prog_steps_down_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    !reload |=> (pcnt == $past(pcnt) - P_W'(1)));

  assert_modctl_stays_low_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (!mod_ctl && !reload) |=> !mod_ctl);

  assert_reload_takes_program_R6: assert property (@(posedge pclk) disable iff (!rst_n)
    reload |=> (pcnt == $past(p_res)) && (scnt == $past(s_res)));

  assert_swallow_not_ahead_R7: assert property (@(posedge pclk) disable iff (!rst_n)
    (pcnt != '0) |-> (int'(scnt) <= int'(pcnt)));
endmodule

// File: tb/pss_divider_counter_test.sv
module pss_divider_counter_test;
  localparam int M = 8;
  localparam int NV = 13;

  typedef struct packed {
    int p; int s; int dn; int ep; int es; int ef;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{24, 3,  0, 24, 3, 0},
    '{24, 3,  3, 24, 6, 0},
    '{24, 2, -4, 23, 6, 0},
    '{27, 5,  3, 28, 0, 0},
    '{23, 2, -3, 22, 7, 0},
    '{ 3, 6,  0,  3, 3, 1},
    '{ 0, 2, -3,  1, 0, 1},
    '{ 1, 1,  0,  1, 1, 0},
    '{ 7, 7,  0,  7, 7, 0},
    '{ 6, 7,  0,  6, 6, 1},
    '{27, 6,  2, 28, 0, 0},
    '{26, 7,  1, 27, 0, 0},
    '{63, 7,  3, 63, 7, 1}
  };

  logic       pclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] prog_p = '0;
  logic [2:0] prog_s = '0;
  logic [2:0] ratio_adj = '0;
  logic       mod_ctl, div_out, clamp_flag;
  int checks = 0;
  int errors = 0;

  always #4 pclk = ~pclk;

  pss_divider_counter uut (
    .pclk(pclk), .rst_n(rst_n), .prog_p(prog_p), .prog_s(prog_s),
    .ratio_adj(ratio_adj), .mod_ctl(mod_ctl), .div_out(div_out),
    .clamp_flag(clamp_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_prog(input int p, input int s, input int dn);
    prog_p = 6'(p); prog_s = 3'(s); ratio_adj = 3'(dn);
  endtask

  // Walks one output cycle at negedges; a period counts 9 with mod_ctl high, else 8.
  task automatic run_cycle(input int swap_at, input int np, input int ns, input int nd,
                           output int n, output int pulses, output int highs,
                           output bit shape_ok, output bit flag);
    bit seen_low = 1'b0;
    n = 0; pulses = 0; highs = 0; shape_ok = 1'b1; flag = 1'b0;
    forever begin
      @(negedge pclk);
      pulses++;
      n += M + (mod_ctl ? 1 : 0);
      if (mod_ctl) begin
        highs++;
        if (seen_low) shape_ok = 1'b0;
      end else seen_low = 1'b1;
      if (pulses == swap_at) set_prog(np, ns, nd);
      if (div_out) begin
        flag = clamp_flag;
        break;
      end
      if (pulses > 200) break;
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, pl, hi, ex;
    bit sh, fl;
    set_prog(VT[0].p, VT[0].s, VT[0].dn);
    repeat (3) @(negedge pclk);
    chk(mod_ctl == 1'b0, "R1 mod_ctl in reset", int'(mod_ctl), 0);
    chk(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
    chk(clamp_flag == 1'b0, "R1 flag in reset", int'(clamp_flag), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_cycle(-1, 0, 0, 0, n, pl, hi, sh, fl);
      ex = VT[i].ep * M + VT[i].es;
      chk(n == ex, "R2 R3 cycle ratio", n, ex);
      chk(pl == VT[i].ep, "R5 periods to div_out", pl, VT[i].ep);
      chk(hi == VT[i].es && sh, "R4 mod_ctl high periods", hi, VT[i].es);
      chk(fl == bit'(VT[i].ef), "R7 R8 clamp_flag", int'(fl), VT[i].ef);
      if (i + 1 < NV) set_prog(VT[i+1].p, VT[i+1].s, VT[i+1].dn);
    end

    // R6: mid-cycle change leaves the running cycle alone, applies next.
    set_prog(24, 3, 0);
    run_cycle(-1, 0, 0, 0, n, pl, hi, sh, fl);
    run_cycle(3, 26, 5, 2, n, pl, hi, sh, fl);
    chk(n == 195, "R6 running cycle kept", n, 195);
    run_cycle(-1, 0, 0, 0, n, pl, hi, sh, fl);
    chk(n == 215, "R6 next cycle updated", n, 215);
    chk(hi == 7, "R6 R4 next swallow", hi, 7);

    // R1: reset in mid-run, then first edge loads the program.
    set_prog(24, 3, 0);
    repeat (5) @(negedge pclk);
    rst_n = 1'b0;
    @(negedge pclk);
    chk(mod_ctl == 1'b0 && div_out == 1'b0, "R1 outputs cleared",
        int'({mod_ctl, div_out}), 0);
    rst_n = 1'b1;
    run_cycle(-1, 0, 0, 0, n, pl, hi, sh, fl);
    chk(n == 195, "R1 first cycle after reset", n, 195);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule